// File: doc/BRIEF.md
# Page write collector with in-page wrap

This block gathers the data bytes of one write transaction into a small page buffer. It then commits them to an external byte-wide array after the transaction's Stop arrives. A transaction opens with a start strobe that carries the word address. The upper address bits select the page and stay fixed for the whole transaction. Only the low page-offset bits form a pointer, which advances after every accepted byte. When the pointer runs past the last slot it folds back to slot 0 of the same page, so an over-long burst overwrites bytes it buffered earlier. A single-byte write is simply a page write of length one.

On a Stop that follows at least one buffered byte, the block raises a busy flag for a fixed number of clock cycles. During the first slots of that window it sweeps the buffer and issues one array write per slot that was actually received. If either write-protect input is high when the Stop is taken, the sweep issues no writes, but busy still lasts the full window. While busy, new starts, bytes and Stops are dropped.

Top module: `page_wbuf`

## Requirements
- R1: After reset, busy_o is 0 and mem_we_o is 0.
- R2: A start_i pulse latches addr_i. Bits [7:4] become the fixed page and bits [3:0] become the slot pointer, and all slot-received marks are cleared.
- R3: Each data_vld_i byte is stored at the current slot and the 4-bit slot pointer then increments modulo 16, leaving the page bits unchanged.
- R4: More than 16 bytes wrap to slot 0 of the same page, and a later byte replaces the earlier byte of that slot; no byte reaches another page.
- R5: No array write occurs before the Stop that ends the transaction.
- R6: After the Stop, exactly one array write is issued for each slot received, at address {page, slot}, with that slot's last data; other addresses are not written.
- R7: A Stop taken with at least one byte buffered makes busy_o 1 from the next cycle for exactly WCYC cycles (WCYC at least 16).
- R8: If hw_wp_i or sw_wp_i is 1 in the Stop cycle, no array write occurs, yet busy_o still lasts WCYC cycles.
- R9: A Stop with no byte buffered since the last start leaves busy_o at 0.
- R10: start_i, data_vld_i and stop_i are ignored while busy_o is 1. When the window ends, the received marks are clear, so the ignored traffic causes no write and no new busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Opens a write transaction |
| addr_i | input | AW | Word address, taken with start_i |
| data_i | input | DW | Data byte |
| data_vld_i | input | 1 | data_i is valid this cycle |
| stop_i | input | 1 | Stop pulse ending the transaction |
| hw_wp_i | input | 1 | Hardware write protect |
| sw_wp_i | input | 1 | Software write protect |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | AW | Array write address |
| mem_wdata_o | output | DW | Array write data |

## Verification
On every cycle, the in-module properties check several things. Array writes occur only inside a busy window. The pointer steps by one modulo 16 while the page bits hold. A loaded Stop opens a busy window and an empty one does not, and every window lasts exactly WCYC cycles. Other behaviour shows only in the final array contents, so only the directed scenarios can reveal it. This covers wrap-around overwriting, the exact set of addresses written and their data, suppression under either protect input, and the discarding of traffic sent while busy.

// File: rtl/page_wbuf.sv
module page_wbuf #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int PB   = 4,
  parameter int WCYC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          data_vld_i,
  input  logic          stop_i,
  input  logic          hw_wp_i,
  input  logic          sw_wp_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int SLOTS = 1 << PB;
  localparam int WC    = (WCYC < SLOTS) ? SLOTS : WCYC;
  localparam int CW    = $clog2(WC + 1);

  logic [DW-1:0]    pbuf [SLOTS];
  logic [SLOTS-1:0] vmask;
  logic [AW-PB-1:0] page_q;
  logic [PB-1:0]    ptr_q, scan_idx;
  logic             busy_q, prot_q, scan_q;
  logic [CW-1:0]    cnt_q;

  wire take_start = start_i & ~busy_q;
  wire take_data  = data_vld_i & ~busy_q & ~start_i;
  wire commit     = stop_i & ~busy_q & ~start_i & ~data_vld_i & (|vmask);

  always_ff @(posedge clk) begin
    if (take_data) pbuf[ptr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmask    <= '0;
      page_q   <= '0;
      ptr_q    <= '0;
      busy_q   <= 1'b0;
      prot_q   <= 1'b0;
      scan_q   <= 1'b0;
      scan_idx <= '0;
      cnt_q    <= '0;
    end else if (busy_q) begin
      if (scan_q) begin
        scan_idx <= scan_idx + 1'b1;
        if (scan_idx == PB'(SLOTS - 1)) scan_q <= 1'b0;
      end
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        vmask  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (take_start) begin
      page_q <= addr_i[AW-1:PB];
      ptr_q  <= addr_i[PB-1:0];
      vmask  <= '0;
    end else if (take_data) begin
      vmask[ptr_q] <= 1'b1;
      ptr_q        <= ptr_q + 1'b1;
    end else if (commit) begin
      busy_q   <= 1'b1;
      cnt_q    <= CW'(WC - 1);
      prot_q   <= hw_wp_i | sw_wp_i;
      scan_q   <= 1'b1;
      scan_idx <= '0;
    end
  end

  assign busy_o      = busy_q;
  assign mem_we_o    = scan_q & vmask[scan_idx] & ~prot_q;
  assign mem_addr_o  = {page_q, scan_idx};
  assign mem_wdata_o = pbuf[scan_idx];

  logic [CW-1:0] bchk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bchk <= '0;
    else if (!busy_o) bchk <= '0;
    else              bchk <= bchk + 1'b1;
  end

  a_r5_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld_i && !start_i && !busy_o) |=> (ptr_q == $past(ptr_q) + PB'(1)) && $stable(page_q));
  a_r7_busy_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && !data_vld_i && !busy_o && (|vmask)) |=> busy_o);
  a_r9_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !busy_o && (vmask == '0)) |=> !busy_o);
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (bchk == CW'(WC)));
  a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (vmask == '0));
endmodule

// File: tb/test_page_wbuf.sv
module test_page_wbuf;
  localparam int WCYC = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, data_vld_i = 0, stop_i = 0, hw_wp_i = 0, sw_wp_i = 0;
  logic [7:0] addr_i = 0, data_i = 0;
  logic busy_o, mem_we_o;
  logic [7:0] mem_addr_o, mem_wdata_o;
  logic [7:0] model [256];
  logic [7:0] expm  [256];
  int wr_cnt = 0, n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  page_wbuf #(.WCYC(WCYC)) i_page_wbuf (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .data_vld_i(data_vld_i), .stop_i(stop_i), .hw_wp_i(hw_wp_i), .sw_wp_i(sw_wp_i),
    .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  always @(negedge clk) if (rst_n && mem_we_o) begin
    model[mem_addr_o] = mem_wdata_o;
    wr_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_array(input string req);
    int bad = 0;
    for (int a = 0; a < 256; a++) if (model[a] !== expm[a]) bad++;
    check(req, bad, 0);
  endtask

  task automatic do_write(input string req, input logic [7:0] a, input int n, input logic [7:0] seed,
                          input logic hw, input logic sw, input bit disturb);
    int w0, blen, nw, hits;
    logic [15:0] got;
    w0 = wr_cnt; got = '0;
    @(negedge clk); start_i = 1; addr_i = a;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < n; i++) begin
      data_vld_i = 1; data_i = seed + 8'(i);
      got[4'(a[3:0] + 4'(i))] = 1'b1;
      if (!(hw | sw)) expm[{a[7:4], 4'(a[3:0] + 4'(i))}] = seed + 8'(i);
      @(negedge clk);
    end
    data_vld_i = 0;
    check({req, " R5 no write before stop"}, wr_cnt - w0, 0);
    hw_wp_i = hw; sw_wp_i = sw; stop_i = 1;
    @(negedge clk); stop_i = 0; hw_wp_i = 0; sw_wp_i = 0;
    blen = 0;
    while (busy_o && blen < 1000) begin
      if (disturb) begin
        if (blen == 2) begin start_i = 1; addr_i = 8'h90; end
        if (blen == 3) begin start_i = 0; data_vld_i = 1; data_i = 8'hEE; end
        if (blen == 4) begin data_vld_i = 0; stop_i = 1; end
        if (blen == 5) stop_i = 0;
      end
      blen++;
      @(negedge clk);
    end
    hits = 0;
    for (int s = 0; s < 16; s++) if (got[s]) hits++;
    nw = (hw | sw) ? 0 : hits;
    check({req, " R7 busy length"}, blen, WCYC);
    check({req, " R6 write count"}, wr_cnt - w0, nw);
    cmp_array({req, " R6 array contents"});
    @(negedge clk);
    check({req, " R10 idle after window"}, int'(busy_o), 0);
  endtask

  task automatic t_reset();
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 we after reset", int'(mem_we_o), 0);
  endtask

  task automatic t_byte();   do_write("R2 byte write", 8'h47, 1, 8'hA5, 0, 0, 0); endtask
  task automatic t_full();   do_write("R3 full page", 8'h20, 16, 8'h10, 0, 0, 0); endtask
  task automatic t_partial(); do_write("R3 partial page", 8'h25, 3, 8'hC0, 0, 0, 0); endtask
  task automatic t_wrap();   do_write("R4 wrap 20 bytes", 8'h3C, 20, 8'h60, 0, 0, 0); endtask
  task automatic t_hw();     do_write("R8 hw protect", 8'h20, 4, 8'h77, 1, 0, 0); endtask
  task automatic t_sw();     do_write("R8 sw protect", 8'h3A, 8, 8'h88, 0, 1, 0); endtask
  task automatic t_busy();   do_write("R10 ignore while busy", 8'hB2, 2, 8'h31, 0, 0, 1); endtask

  task automatic t_empty();
    int w0 = wr_cnt;
    @(negedge clk); start_i = 1; addr_i = 8'h50;
    @(negedge clk); start_i = 0; stop_i = 1;
    @(negedge clk); stop_i = 0;
    check("R9 empty stop busy", int'(busy_o), 0);
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    check("R9 bare stop busy", int'(busy_o), 0);
    check("R9 no writes", wr_cnt - w0, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin model[a] = 8'h00; expm[a] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_full();
    t_partial();
    t_wrap();
    t_hw();
    t_sw();
    t_empty();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule